// File: doc/BRIEF.md
# Three-Byte Instruction Fetch and Execute Sequencer

This block is the control core of a very small 8-bit accumulator processor. Every instruction is three bytes long: an opcode followed by a low and a high operand byte. The core reads these bytes one at a time from an external synchronous single-port RAM. That RAM returns data one clock after it samples an address. The core decodes the opcode and then executes it against a single accumulator.

The core moves through a fixed ring of states. Each byte costs a wait state, so that the RAM can present the byte, and then a fetch state, in which the core captures it. After the three bytes come one decode cycle and one execute cycle, so every instruction takes eight clocks. In decode the core places the operand address on the RAM bus whatever the opcode is. A memory load can therefore read its data during execute, and a store can write during execute. Debug outputs show the three instruction registers and the accumulator.

Top module: `acc_seq_core`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the core is in its wakeup cycle. It drives `mem_addr` = 0x0000, holds `mem_we` low and has the accumulator at 0x00. The first opcode is fetched from address 0.
- R2: After wakeup, each instruction takes exactly 8 cycles: wait1, fetch1, wait2, fetch2, wait3, fetch3, decode and execute. In wait1, wait2 and wait3, `mem_addr` is PC, PC+1 and PC+2, where PC is the address of the opcode.
- R3: The bytes at PC, PC+1 and PC+2 end up in instruction registers 1, 2 and 3 (`dbg_ir1`, `dbg_ir2`, `dbg_ir3`). The address advances by one after fetch1 and after fetch2, and it does not advance after fetch3.
- R4: During decode, `mem_addr` equals the operand address {`dbg_ir3`, `dbg_ir2`}, with IR3 as the high byte, for every opcode.
- R5: Opcode 0x01 (load immediate) loads the accumulator with IR2 at the clock edge that ends execute.
- R6: Opcode 0x02 (load absolute) loads the accumulator with the RAM byte at {IR3, IR2} at the clock edge that ends execute. This includes a byte that an earlier store wrote.
- R7: Opcode 0x03 (store absolute) raises `mem_we` for exactly one cycle, the execute cycle, with `mem_addr` = {IR3, IR2} and `mem_wdata` = accumulator. No other instruction raises `mem_we`.
- R8: Opcode 0x04 (jump) makes the next instruction start at {IR3, IR2}. The accumulator is unchanged.
- R9: Any other opcode, such as 0x00 or 0xFF, is a no-op. The accumulator is unchanged, nothing is written, and the next instruction starts at PC+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | RAM address |
| mem_rdata | input | 8 | RAM read data, valid one cycle after the address |
| mem_wdata | output | 8 | RAM write data (accumulator) |
| mem_we | output | 1 | RAM write enable |
| dbg_ir1 | output | 8 | Instruction register 1 (opcode) |
| dbg_ir2 | output | 8 | Instruction register 2 (operand low byte) |
| dbg_ir3 | output | 8 | Instruction register 3 (operand high byte) |
| dbg_acc | output | 8 | Accumulator |

## Verification
The assertions check, on every cycle, the reset value of the address, the single-cycle write strobe and its operand address, and the address step after fetch1 and fetch2. They also check the accumulator update at the end of execute for each opcode class and the redirect of the address after a jump. Only the bench's program can show the full eight-cycle rhythm and the contents the instruction registers capture. The same holds for a store followed by a load that reads the stored byte back, and for PC progression across chained jumps and no-ops.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OPC_LDI = 8'h01;
    localparam logic [OPC_W-1:0] OPC_LDA = 8'h02;
    localparam logic [OPC_W-1:0] OPC_STA = 8'h03;
    localparam logic [OPC_W-1:0] OPC_JMP = 8'h04;

    typedef enum logic [3:0] {
        ST_WAKE,
        ST_WAIT1,
        ST_FETCH1,
        ST_WAIT2,
        ST_FETCH2,
        ST_WAIT3,
        ST_FETCH3,
        ST_DECODE,
        ST_EXEC
    } seq_state_e;

    typedef enum logic [2:0] {
        K_NOP,
        K_LDI,
        K_LDA,
        K_STA,
        K_JMP
    } op_kind_e;

    typedef struct packed {
        logic inc;
        logic load;
    } pc_ctl_t;

    function automatic op_kind_e classify(logic [OPC_W-1:0] opc);
        case (opc)
            OPC_LDI: return K_LDI;
            OPC_LDA: return K_LDA;
            OPC_STA: return K_STA;
            OPC_JMP: return K_JMP;
            default: return K_NOP;
        endcase
    endfunction

    function automatic seq_state_e fetch_state_of(int unsigned slot);
        case (slot)
            0:       return ST_FETCH1;
            1:       return ST_FETCH2;
            default: return ST_FETCH3;
        endcase
    endfunction

endpackage

// File: rtl/seq_fsm.sv
module seq_fsm
    import seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    output seq_state_e state
);

    seq_state_e nxt;

    always_comb begin
        case (state)
            ST_WAKE:   nxt = ST_WAIT1;
            ST_WAIT1:  nxt = ST_FETCH1;
            ST_FETCH1: nxt = ST_WAIT2;
            ST_WAIT2:  nxt = ST_FETCH2;
            ST_FETCH2: nxt = ST_WAIT3;
            ST_WAIT3:  nxt = ST_FETCH3;
            ST_FETCH3: nxt = ST_DECODE;
            ST_DECODE: nxt = ST_EXEC;
            ST_EXEC:   nxt = ST_WAIT1;
            default:   nxt = ST_WAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_WAKE;
        else     state <= nxt;
    end

    // R2: execute is always followed by wait1
    assert_exec_to_wait_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC) |=> (state == ST_WAIT1));

endmodule

// File: rtl/seq_pc.sv
module seq_pc
    import seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  pc_ctl_t           ctl,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc
);

    always_ff @(posedge clk) begin
        if (rst)           pc <= '0;
        else if (ctl.load) pc <= target;
        else if (ctl.inc)  pc <= pc + ADDR_W'(1);
    end

    // R1: reset clears the program counter
    assert_pc_reset_R1: assert property (@(posedge clk)
        rst |=> (pc == '0));

endmodule

// File: rtl/seq_regs.sv
module seq_regs
    import seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NUM_IR = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  seq_state_e                    state,
    input  op_kind_e                      kind,
    input  logic [DATA_W-1:0]             rdata,
    output logic [NUM_IR-1:0][DATA_W-1:0] ir,
    output logic [DATA_W-1:0]             acc
);

    logic [DATA_W-1:0] ir_q [NUM_IR];

    for (genvar k = 0; k < NUM_IR; k++) begin : g_ir
        always_ff @(posedge clk) begin
            if (rst)
                ir_q[k] <= '0;
            else if (state == fetch_state_of(k))
                ir_q[k] <= rdata;
        end
        assign ir[k] = ir_q[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (state == ST_EXEC) begin
            case (kind)
                K_LDI:   acc <= ir_q[1];
                K_LDA:   acc <= rdata;
                default: acc <= acc;
            endcase
        end
    end

    // R5: load immediate takes operand low byte
    assert_acc_ldi_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && kind == K_LDI) |=> (acc == $past(ir[1])));

    // R6: load absolute takes the RAM byte presented in execute
    assert_acc_lda_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && kind == K_LDA) |=> (acc == $past(rdata)));

    // R9: store, jump and no-op leave the accumulator alone
    assert_acc_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && (kind == K_NOP || kind == K_STA || kind == K_JMP))
        |=> $stable(acc));

endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
    import seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [DATA_W-1:0] dbg_ir1,
    output logic [DATA_W-1:0] dbg_ir2,
    output logic [DATA_W-1:0] dbg_ir3,
    output logic [DATA_W-1:0] dbg_acc
);

    localparam int NUM_IR = 3;

    seq_state_e                    state;
    op_kind_e                      kind;
    pc_ctl_t                       pc_ctl;
    logic [ADDR_W-1:0]             pc;
    logic [ADDR_W-1:0]             operand;
    logic [NUM_IR-1:0][DATA_W-1:0] ir;
    logic                          use_operand;

    seq_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .state (state)
    );

    seq_regs #(
        .DATA_W (DATA_W),
        .NUM_IR (NUM_IR)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .state (state),
        .kind  (kind),
        .rdata (mem_rdata),
        .ir    (ir),
        .acc   (dbg_acc)
    );

    seq_pc #(
        .ADDR_W (ADDR_W)
    ) u_pc (
        .clk    (clk),
        .rst    (rst),
        .ctl    (pc_ctl),
        .target (operand),
        .pc     (pc)
    );

    assign kind    = classify(ir[0][OPC_W-1:0]);
    assign operand = ADDR_W'({ir[2], ir[1]});

    always_comb begin
        pc_ctl.inc  = 1'b0;
        pc_ctl.load = 1'b0;
        case (state)
            ST_FETCH1, ST_FETCH2: pc_ctl.inc = 1'b1;
            ST_EXEC: begin
                if (kind == K_JMP) pc_ctl.load = 1'b1;
                else               pc_ctl.inc  = 1'b1;
            end
            default: ;
        endcase
    end

    assign use_operand = (state == ST_DECODE) || (state == ST_EXEC && kind == K_STA);
    assign mem_addr    = use_operand ? operand : pc;
    assign mem_we      = (state == ST_EXEC) && (kind == K_STA);
    assign mem_wdata   = dbg_acc;

    assign dbg_ir1 = ir[0];
    assign dbg_ir2 = ir[1];
    assign dbg_ir3 = ir[2];

    // R1: reset drives address zero with no write
    assert_reset_addr_R1: assert property (@(posedge clk)
        rst |=> (mem_addr == '0 && !mem_we));

    // R3: address steps by one after fetch1 and fetch2
    assert_fetch_step_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH1 || state == ST_FETCH2)
        |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R7: write strobe lasts one cycle
    assert_we_single_R7: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R7: write goes to the operand address
    assert_we_addr_R7: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr == ADDR_W'({dbg_ir3, dbg_ir2})));

    // R8: after a jump the next fetch address is the target
    assert_jump_target_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && kind == K_JMP)
        |=> (mem_addr == ADDR_W'({$past(dbg_ir3), $past(dbg_ir2)})));

endmodule

// File: tb/acc_seq_core_tb.sv
module acc_seq_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  dbg_ir1, dbg_ir2, dbg_ir3, dbg_acc;

    always #10 clk = ~clk;

    acc_seq_core u_dut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .dbg_ir1   (dbg_ir1),
        .dbg_ir2   (dbg_ir2),
        .dbg_ir3   (dbg_ir3),
        .dbg_acc   (dbg_acc)
    );

    logic [7:0] ram    [1024];
    logic [7:0] shadow [1024];

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr[9:0]] <= mem_wdata;
        mem_rdata <= ram[mem_addr[9:0]];
    end

    typedef struct {
        logic [15:0] pc;
        logic [7:0]  op, lo, hi;
        logic [7:0]  acc_before;
        logic [7:0]  acc_after;
        logic [15:0] next_pc;
        int          we_cnt;
        string       tag;
    } item_t;

    item_t queue_q[$];

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] pc_m  = 16'h0000;
    logic [7:0]  acc_m = 8'h00;

    task automatic chk(string req, int act, int exp, string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // driver: places an instruction in RAM and queues its expected outcome
    task automatic issue(logic [7:0] op, logic [7:0] lo, logic [7:0] hi);
        item_t it;
        logic [15:0] opnd;
        opnd          = {hi, lo};
        it.pc         = pc_m;
        it.op         = op;
        it.lo         = lo;
        it.hi         = hi;
        it.acc_before = acc_m;
        it.we_cnt     = 0;
        it.next_pc    = pc_m + 16'd3;
        case (op)
            8'h01: begin acc_m = lo; it.tag = "R5"; end
            8'h02: begin acc_m = shadow[opnd[9:0]]; it.tag = "R6"; end
            8'h03: begin shadow[opnd[9:0]] = acc_m; it.we_cnt = 1; it.tag = "R7"; end
            8'h04: begin it.next_pc = opnd; it.tag = "R8"; end
            default: it.tag = "R9";
        endcase
        it.acc_after = acc_m;
        ram[pc_m[9:0]]            = op;
        ram[pc_m[9:0] + 10'd1]    = lo;
        ram[pc_m[9:0] + 10'd2]    = hi;
        shadow[pc_m[9:0]]         = op;
        shadow[pc_m[9:0] + 10'd1] = lo;
        shadow[pc_m[9:0] + 10'd2] = hi;
        pc_m = it.next_pc;
        queue_q.push_back(it);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        item_t it;
        int    we_seen;
        for (int i = 0; i < 1024; i++) begin
            ram[i]    = 8'h00;
            shadow[i] = 8'h00;
        end
        ram[10'h300]    = 8'h5A;
        shadow[10'h300] = 8'h5A;

        issue(8'h01, 8'hCA, 8'h00);   // R5
        issue(8'h03, 8'h00, 8'h02);   // R7 store to 0x0200
        issue(8'h01, 8'h35, 8'h00);   // R5
        issue(8'h02, 8'h00, 8'h03);   // R6 preloaded byte
        issue(8'h02, 8'h00, 8'h02);   // R6 read back stored byte
        issue(8'h00, 8'h01, 8'h03);   // R9
        issue(8'hFF, 8'h00, 8'h02);   // R9
        issue(8'h04, 8'h00, 8'h01);   // R8 jump to 0x0100
        issue(8'h01, 8'h77, 8'h00);   // R5
        issue(8'h03, 8'h01, 8'h02);   // R7 store to 0x0201
        issue(8'h04, 8'h40, 8'h00);   // R8 jump backwards to 0x0040
        issue(8'h02, 8'h01, 8'h02);   // R6
        issue(8'h01, 8'h00, 8'h00);   // R5 zero value
        issue(8'h04, 8'h46, 8'h00);   // R8 jump to self

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1", mem_addr, 16'h0000, "address in wakeup");
        chk("R1", mem_we, 0, "write enable in wakeup");
        chk("R1", dbg_acc, 8'h00, "accumulator after reset");
        @(negedge clk);
        chk("R1", mem_addr, 16'h0000, "first fetch address");

        // monitor: pops expected items as instructions complete
        while (queue_q.size() > 0) begin
            it = queue_q.pop_front();
            we_seen = 0;
            for (int c = 0; c < 8; c++) begin
                case (c)
                    0: chk("R2", mem_addr, it.pc, "wait1 address");
                    2: chk("R2", mem_addr, it.pc + 16'd1, "wait2 address");
                    4: chk("R2", mem_addr, it.pc + 16'd2, "wait3 address");
                    6: begin
                        chk("R3", dbg_ir1, it.op, "IR1 opcode");
                        chk("R3", dbg_ir2, it.lo, "IR2 low byte");
                        chk("R3", dbg_ir3, it.hi, "IR3 high byte");
                        chk("R4", mem_addr, {it.hi, it.lo}, "decode address");
                    end
                    7: begin
                        if (it.we_cnt == 1) begin
                            chk("R7", mem_we, 1, "write enable in execute");
                            chk("R7", mem_addr, {it.hi, it.lo}, "store address");
                            chk("R7", mem_wdata, it.acc_before, "store data");
                        end
                    end
                    default: ;
                endcase
                if (mem_we === 1'b1) we_seen++;
                @(negedge clk);
            end
            chk(it.tag, dbg_acc, it.acc_after, "accumulator after execute");
            chk(it.tag, mem_addr, it.next_pc, "next instruction address");
            chk("R7", we_seen, it.we_cnt, "write cycles in instruction");
            if (it.we_cnt == 1)
                chk("R7", ram[{it.hi[1:0], it.lo}], it.acc_before, "RAM after store");
        end
        finish_up();
    end

endmodule